// File: doc/BRIEF.md
# Interrupt Source-to-Channel Router

This block takes a wide vector of level-sensitive device interrupt lines and folds them onto eight hardware interrupt channels of a processor. Every source owns a small configuration entry made of an enable bit and a channel number. A source can therefore be routed to any hardware channel, or left unconnected. Any number of sources may share a channel. Each channel output is the OR of the live levels of the sources routed to it. The first few channels, a count set by a parameter, also feed a wake output that is used while the chip is in deep sleep.

Software reaches the block through a plain synchronous strobe/index/data port. The same source index serves both to write an entry and to disconnect it, so a disconnect does not need the channel number. Two lookups support the interrupt handler. A registered query takes a channel number and reports the lowest-indexed source that is active on that channel. A combinational reverse lookup takes a source index and reports the channel the source feeds. Channel numbers 8 to 15 are reserved for software-only interrupts, and no source is ever routed to them.

Top module: `irq_route`

## Requirements
- R1: After reset every source is unconnected. All channel outputs and the wake output are 0 even when source lines are high, `qry_valid_o` is 0, and every reverse lookup returns 0xF.
- R2: A strobe on `cfg_wr_i` with `cfg_idx_i` below NUM_SRC loads that source's entry from `cfg_data_i`, where bit 3 is the enable and bits 2:0 are the hardware channel. The new entry takes effect from the next clock edge.
- R3: `ch_irq_o[c]` is, without any register, the OR of the current levels of all sources that are enabled and routed to channel c. Levels are active-high and are not latched.
- R4: A query strobe on `qry_req_i` for channel c (0 to 7) gives `qry_valid_o` = 1 for exactly the following cycle. In that cycle `qry_src_o` holds the lowest source index that was enabled, routed to c and active when the strobe was sampled. For example, if sources 29 and 46 are both active on the channel, the result is 29.
- R5: The query returns the code 0x3FF when no source on the queried channel is active, and always when the queried channel is 8 to 15.
- R6: `lookup_ch_o` returns the channel (0 to 7, zero-extended to 4 bits) of the source at `lookup_idx_i`. It returns 0xF when that source is disabled or when the index is not below NUM_SRC.
- R7: A strobe on `cfg_disc_i` clears the enable of the source at `cfg_idx_i` from the next edge. When a write and a disconnect hit the same cycle, the disconnect wins.
- R8: A write or disconnect whose index is not below NUM_SRC changes no entry. Index 1023 is therefore never routable.
- R9: `wake_o` is 1 exactly when a channel below NUM_WAKE_CH has an active output. Sources routed to higher channels never raise it.
- R10: The query is evaluated with the configuration written in the same cycle as the query strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | NUM_SRC | Device interrupt levels, active-high |
| cfg_wr_i | input | 1 | Write strobe for one source entry |
| cfg_disc_i | input | 1 | Disconnect strobe for one source |
| cfg_idx_i | input | 10 | Source index for a write or disconnect |
| cfg_data_i | input | 4 | Entry data: bit 3 enable, bits 2:0 channel |
| qry_req_i | input | 1 | Active-source query strobe |
| qry_ch_i | input | 4 | Channel to query (8 to 15 are software-only) |
| qry_valid_o | output | 1 | Query result valid, one cycle after the strobe |
| qry_src_o | output | 10 | Winning source index, or 0x3FF for none |
| lookup_idx_i | input | 10 | Source index for the reverse lookup |
| lookup_ch_o | output | 4 | Channel of that source, or 0xF when unconnected |
| ch_irq_o | output | 8 | Hardware channel interrupt outputs |
| wake_o | output | 1 | Deep-sleep wake request |

## Verification
The assertions assume that `qry_req_i` stays low while reset is held, so that the first post-reset check of the valid pulse refers to a quiet cycle. They also assume that interrupt levels and strobes are synchronous to the clock. Indexes outside the populated range are legal input and are expected to be ignored rather than excluded. The stimulus drives every input on the falling edge, keeps the query strobe low during reset, and deliberately issues out-of-range indexes, write/disconnect collisions and writes in the same cycle as a query.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int IDX_W    = 10;
    localparam int HW_CH    = 8;
    localparam int CH_W     = $clog2(HW_CH);
    localparam int CODE_W   = 4;
    localparam logic [IDX_W-1:0]  SRC_NONE = 10'h3FF;
    localparam logic [CODE_W-1:0] CH_NONE  = 4'hF;

    typedef struct packed {
        logic            en;
        logic [CH_W-1:0] ch;
    } src_cfg_t;
endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic                    disc_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [CODE_W-1:0]       data_i,
    output src_cfg_t [NUM_SRC-1:0]  cfg_d_o,
    output src_cfg_t [NUM_SRC-1:0]  cfg_q_o
);
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [IDX_W-1:0] SRC_LAST = IDX_W'(NUM_SRC - 1);

    typedef struct packed {
        src_cfg_t [NUM_SRC-1:0] tab;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic             in_range;
    logic [SEL_W-1:0] sel;

    assign in_range = (idx_i <= SRC_LAST);
    assign sel      = idx_i[SEL_W-1:0];

    always_comb begin
        st_d = st_q;
        if (in_range) begin
            if (disc_i) begin
                st_d.tab[sel].en = 1'b0;
            end else if (wr_i) begin
                st_d.tab[sel] = src_cfg_t'(data_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_d_o = st_d.tab;
    assign cfg_q_o = st_q.tab;

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !disc_i && in_range) |=> (st_q.tab[$past(sel)] == src_cfg_t'($past(data_i))));

    // R7
    disc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_i && in_range) |=> !st_q.tab[$past(sel)].en);

    // R8
    oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |=> $stable(st_q));
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC     = 64,
    parameter int NUM_WAKE_CH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     irq_src_i,
    input  src_cfg_t [NUM_SRC-1:0] cfg_i,
    output logic [HW_CH-1:0]       ch_irq_o,
    output logic                   wake_o
);
    for (genvar c = 0; c < HW_CH; c++) begin : g_ch
        logic [NUM_SRC-1:0] hit;
        always_comb begin
            for (int i = 0; i < NUM_SRC; i++) begin
                hit[i] = irq_src_i[i] & cfg_i[i].en & (cfg_i[i].ch == CH_W'(c));
            end
        end
        assign ch_irq_o[c] = |hit;
    end

    assign wake_o = |ch_irq_o[NUM_WAKE_CH-1:0];

    // R3
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src_i == '0) |-> (ch_irq_o == '0));

    // R9
    wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (irq_src_i != '0));
endmodule

// File: rtl/irq_route_query.sv
module irq_route_query
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic [CODE_W-1:0]      ch_i,
    input  logic [NUM_SRC-1:0]     irq_src_i,
    input  src_cfg_t [NUM_SRC-1:0] cfg_nx_i,
    output logic                   valid_o,
    output logic [IDX_W-1:0]       src_o
);
    localparam logic [IDX_W-1:0] SRC_LAST = IDX_W'(NUM_SRC - 1);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] src;
    } qry_state_t;

    qry_state_t st_d, st_q;
    logic [IDX_W-1:0] win;

    always_comb begin
        win = SRC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (!ch_i[CODE_W-1] && cfg_nx_i[i].en && (cfg_nx_i[i].ch == ch_i[CH_W-1:0])
                && irq_src_i[i]) begin
                win = IDX_W'(i);
            end
        end
        st_d       = st_q;
        st_d.valid = req_i;
        if (req_i) begin
            st_d.src = win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, src: SRC_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign src_o   = st_q.src;

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == $past(req_i));

    // R4
    src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ((src_o == SRC_NONE) || (src_o <= SRC_LAST)));

    // R5
    sw_ch_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ch_i[CODE_W-1]) |=> (src_o == SRC_NONE));

    // R5
    idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (irq_src_i == '0)) |=> (src_o == SRC_NONE));
endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC     = 64,
    parameter int NUM_WAKE_CH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic               cfg_wr_i,
    input  logic               cfg_disc_i,
    input  logic [9:0]         cfg_idx_i,
    input  logic [3:0]         cfg_data_i,
    input  logic               qry_req_i,
    input  logic [3:0]         qry_ch_i,
    output logic               qry_valid_o,
    output logic [9:0]         qry_src_o,
    input  logic [9:0]         lookup_idx_i,
    output logic [3:0]         lookup_ch_o,
    output logic [7:0]         ch_irq_o,
    output logic               wake_o
);
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [IDX_W-1:0] SRC_LAST = IDX_W'(NUM_SRC - 1);

    src_cfg_t [NUM_SRC-1:0] cfg_d, cfg_q;
    logic                   lk_in_range;
    src_cfg_t               lk_ent;

    irq_route_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr_i),
        .disc_i  (cfg_disc_i),
        .idx_i   (cfg_idx_i),
        .data_i  (cfg_data_i),
        .cfg_d_o (cfg_d),
        .cfg_q_o (cfg_q)
    );

    irq_route_merge #(.NUM_SRC(NUM_SRC), .NUM_WAKE_CH(NUM_WAKE_CH)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src_i (irq_src_i),
        .cfg_i     (cfg_q),
        .ch_irq_o  (ch_irq_o),
        .wake_o    (wake_o)
    );

    irq_route_query #(.NUM_SRC(NUM_SRC)) u_query (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (qry_req_i),
        .ch_i      (qry_ch_i),
        .irq_src_i (irq_src_i),
        .cfg_nx_i  (cfg_d),
        .valid_o   (qry_valid_o),
        .src_o     (qry_src_o)
    );

    // R6: reverse lookup
    assign lk_in_range = (lookup_idx_i <= SRC_LAST);
    assign lk_ent      = cfg_q[lookup_idx_i[SEL_W-1:0]];
    assign lookup_ch_o = (lk_in_range && lk_ent.en) ? {1'b0, lk_ent.ch} : CH_NONE;
endmodule

// File: tb/irq_route_tb.sv
`timescale 1ns/1ps
module irq_route_tb;
    localparam int NSRC  = 64;
    localparam int NWAKE = 4;
    localparam real TCK  = 20.0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_src_i = '0;
    logic            cfg_wr_i = 1'b0, cfg_disc_i = 1'b0;
    logic [9:0]      cfg_idx_i = '0;
    logic [3:0]      cfg_data_i = '0;
    logic            qry_req_i = 1'b0;
    logic [3:0]      qry_ch_i = '0;
    logic            qry_valid_o;
    logic [9:0]      qry_src_o;
    logic [9:0]      lookup_idx_i = '0;
    logic [3:0]      lookup_ch_o;
    logic [7:0]      ch_irq_o;
    logic            wake_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic       m_en [NSRC];
    logic [2:0] m_ch [NSRC];

    always #(TCK/2) clk = ~clk;

    irq_route #(.NUM_SRC(NSRC), .NUM_WAKE_CH(NWAKE)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i),
        .cfg_wr_i(cfg_wr_i), .cfg_disc_i(cfg_disc_i), .cfg_idx_i(cfg_idx_i),
        .cfg_data_i(cfg_data_i), .qry_req_i(qry_req_i), .qry_ch_i(qry_ch_i),
        .qry_valid_o(qry_valid_o), .qry_src_o(qry_src_o),
        .lookup_idx_i(lookup_idx_i), .lookup_ch_o(lookup_ch_o),
        .ch_irq_o(ch_irq_o), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] mq(input logic [3:0] c, input logic [NSRC-1:0] v);
        mq = 10'h3FF;
        if (!c[3]) begin
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (m_en[i] && m_ch[i] == c[2:0] && v[i]) mq = 10'(i);
            end
        end
    endfunction

    function automatic logic [7:0] mch(input logic [NSRC-1:0] v);
        mch = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (m_en[i] && v[i]) mch[m_ch[i]] = 1'b1;
        end
    endfunction

    function automatic logic [3:0] mlk(input logic [9:0] k);
        if (k < NSRC && m_en[k]) mlk = {1'b0, m_ch[k]};
        else mlk = 4'hF;
    endfunction

    // One cycle: drive at a falling edge, check at the next falling edge.
    task automatic step(input logic wr, input logic disc, input logic [9:0] idx,
                        input logic [3:0] data, input logic req, input logic [3:0] qch,
                        input logic [NSRC-1:0] irq, input logic [9:0] lk,
                        input string qtag, input string ltag);
        logic [9:0] exp_src;
        logic [7:0] exp_ch;
        cfg_wr_i = wr; cfg_disc_i = disc; cfg_idx_i = idx; cfg_data_i = data;
        qry_req_i = req; qry_ch_i = qch; irq_src_i = irq;
        if (idx < NSRC) begin
            if (disc) m_en[idx] = 1'b0;
            else if (wr) begin m_en[idx] = data[3]; m_ch[idx] = data[2:0]; end
        end
        exp_src = mq(qch, irq);
        @(negedge clk);
        cfg_wr_i = 1'b0; cfg_disc_i = 1'b0; qry_req_i = 1'b0;
        chk("R4 valid", 32'(qry_valid_o), 32'(req));
        if (req) chk((exp_src == 10'h3FF) ? "R5 none" : qtag, 32'(qry_src_o), 32'(exp_src));
        exp_ch = mch(irq);
        chk("R3 channels", 32'(ch_irq_o), 32'(exp_ch));
        chk("R9 wake", 32'(wake_o), 32'(|exp_ch[NWAKE-1:0]));
        lookup_idx_i = lk;
        #1;
        chk(ltag, 32'(lookup_ch_o), 32'(mlk(lk)));
    endtask

    initial begin
        #(TCK * 200000);
        chk("watchdog", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [NSRC-1:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NSRC; i++) begin m_en[i] = 1'b0; m_ch[i] = '0; end
        irq_src_i = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state with every source line high
        chk("R1 channels", 32'(ch_irq_o), 32'd0);
        chk("R1 wake", 32'(wake_o), 32'd0);
        chk("R1 valid", 32'(qry_valid_o), 32'd0);
        lookup_idx_i = 10'd0;  #1; chk("R1 lookup", 32'(lookup_ch_o), 32'hF);
        lookup_idx_i = 10'd63; #1; chk("R1 lookup", 32'(lookup_ch_o), 32'hF);

        // R2/R4: sources 29 and 46 share channel 2, lower index wins
        step(1, 0, 10'd29, 4'b1010, 0, 4'd0, '0, 10'd29, "R4", "R2 lookup");
        step(1, 0, 10'd46, 4'b1010, 0, 4'd0, '0, 10'd46, "R4", "R2 lookup");
        v = '0; v[29] = 1'b1; v[46] = 1'b1;
        step(0, 0, 10'd0, 4'd0, 1, 4'd2, v, 10'd29, "R4 lowest index", "R6 lookup");
        // R5: software-only channel and idle channel
        step(0, 0, 10'd0, 4'd0, 1, 4'd10, v, 10'd46, "R5", "R6 lookup");
        step(0, 0, 10'd0, 4'd0, 1, 4'd2, '0, 10'd46, "R5", "R6 lookup");
        // R10: write and query in the same cycle
        v = '0; v[3] = 1'b1;
        step(1, 0, 10'd3, 4'b1100, 1, 4'd4, v, 10'd3, "R10 same-cycle", "R2 lookup");
        // R8: out-of-range write must not alias onto source 6
        step(1, 0, 10'd70, 4'b1001, 0, 4'd0, '0, 10'd6, "R4", "R8 oob write");
        step(1, 0, 10'd1023, 4'b1001, 0, 4'd0, '1, 10'd63, "R4", "R8 oob write");
        step(0, 0, 10'd0, 4'd0, 0, 4'd0, '0, 10'd70, "R4", "R6 oob lookup");
        // R9: channel 5 must not wake, channel 1 must
        v = '0; v[10] = 1'b1;
        step(1, 0, 10'd10, 4'b1101, 0, 4'd0, v, 10'd10, "R4", "R2 lookup");
        step(0, 0, 10'd0, 4'd0, 1, 4'd5, v, 10'd10, "R4", "R6 lookup");
        step(1, 0, 10'd10, 4'b1001, 0, 4'd0, v, 10'd10, "R4", "R2 lookup");
        step(0, 0, 10'd0, 4'd0, 0, 4'd0, v, 10'd10, "R4", "R6 lookup");
        // R7: disconnect beats a simultaneous write, then plain disconnect
        step(1, 1, 10'd29, 4'b1011, 0, 4'd0, '0, 10'd29, "R4", "R7 disc wins");
        step(0, 1, 10'd46, 4'd0, 0, 4'd0, '0, 10'd46, "R4", "R7 disconnect");
        v = '0; v[46] = 1'b1;
        step(0, 0, 10'd0, 4'd0, 1, 4'd2, v, 10'd46, "R7 query", "R7 lookup");

        // Random phase
        for (int it = 0; it < 3000; it++) begin
            int op;
            logic wr, disc, req;
            logic [9:0] idx;
            op   = int'($urandom % 8);
            wr   = (op <= 2) || (op == 4);
            disc = (op == 3) || (op == 4);
            idx  = 10'($urandom % 68);
            req  = 1'($urandom % 2);
            v    = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            step(wr, disc, idx, 4'($urandom), req, 4'($urandom % 10), v,
                 10'($urandom % 68), "R4 random", "R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule